// File: doc/BRIEF.md
# Match-Driven Debug Trigger Sequencer

This block turns comparator match pulses into a single debug trigger by walking a small programmable state machine. Three match inputs, each gated by its own enable bit, move the sequencer among State1, State2, State3 and Final. When Final is reached the block fires a one-cycle trigger, disarms itself and records which match caused the trigger.

Each of the three working states has a 4-bit selector. The selector picks one entry from a fixed menu of match-to-state mappings. The three selectors and the match-flag register all sit behind one bus address. A bank-select field in the control register chooses which of them is visible there. Software first programs the selectors while the sequencer is idle and then arms it. It waits for the trigger and reads the flags afterwards.

The bus has two addresses. Address 0 is the control register. Address 1 is the banked window. Reads are combinational and writes take effect at the clock edge.

Top module: `dbg_trig_seq`

## Requirements
- R1: An active-low reset clears every register. After reset the sequencer is disarmed, `state_o` is 00 (State1), `trig_o` is 0 and reads at both addresses return 0.
- R2: The control register sits at address 0 and always accepts writes. Its fields are: bit 7 arm, bits 6:4 the enables (bit 4+k enables Match k), and bits 1:0 the bank select. Bits 3:2 read as zero. Writing arm=1 while disarmed puts the sequencer in State1 and clears the match flags. Writing arm=0 disarms and leaves the state unchanged. In a cycle with a control write the sequencer does not step.
- R3: Address 1 shows the State1 selector when the bank is 00, the State2 selector for 01, the State3 selector for 10, and the match flags for 11. A selector sits in bits 3:0 and bits 7:4 read as zero. The match flags sit in bits 2:0, with bit k standing for Match k.
- R4: A write to address 1 updates the selector the bank points at, but only while disarmed. Writes while armed are ignored. Writes with bank 11 are ignored.
- R5: State encoding on `state_o` is 00 State1, 01 State2, 10 State3, 11 Final. Every working state uses the same code table, each reading its own selector. The codes are: 0000 any match to Final; 0001 Match1 to State3; 0010 Match2 to State2; 0011 Match1 to State2; 0100 Match0 to State2 and Match1 to State3; 0101 Match0 to Final and Match1 to State3; 0110 Match0 to State2 and Match2 to State3; 0111 Match0 or Match1 to State2; 1001 Match0 to State3. Code 1000 and codes 1010 to 1111 cause no transition.
- R6: A match has no effect when the current code does not name it, when its enable bit is clear, or when the sequencer is disarmed.
- R7: When several named matches arrive in one cycle, a transition to Final wins. Otherwise the lowest-numbered match decides the next state.
- R8: The state changes at the clock edge that samples the match. On entering Final, `trig_o` is high for exactly the following cycle, arm is cleared, and the match flags hold only the bit of the causing match. Final is held until the sequencer is re-armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 control register, 1 banked window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| match_i | input | 3 | Match pulses, bit k is Match k |
| trig_o | output | 1 | One-cycle trigger pulse |
| state_o | output | 2 | Current sequencer state |

## Verification
The bench sends simultaneous matches against codes that name several of them. A design with the wrong priority would step to State2 or State3 instead of Final, or would take the higher-numbered match. Every code from 0000 to 1001 is run against each single match, and the reserved codes get all three matches at once. A decoder that is off by one entry, or that treats reserved codes as "any match", would move when it should hold. The bench also writes selectors while armed, writes with bank 11, and writes to disabled channels. A leaky write gate or a missing enable mask would change the read-back or the state. Finally, a random stream mixing arming with matches checks that the trigger lasts one cycle and that arming wins over a step in the same cycle.

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [2:0]    match_i,
  output logic          trig_o,
  output logic [1:0]    state_o
);
  localparam int NM = 3;
  localparam int SW = 4;
  localparam logic [1:0] S1 = 2'd0, S2 = 2'd1, S3 = 2'd2, SF = 2'd3;

  logic          armed_q, trig_q;
  logic [NM-1:0] en_q, mflag_q;
  logic [1:0]    bank_q, state_q;
  logic [SW-1:0] sel_q [0:2];
  logic [SW-1:0] cur_code;
  logic [NM-1:0] eff, fin_cause;
  logic          fin_hit, any_hit;
  logic [1:0]    low_state, nxt_state;
  logic [2:0]    t;

  wire ctrl_wr = bus_wr & ~bus_addr;
  wire sel_wr  = bus_wr & bus_addr & ~armed_q & (bank_q != 2'd3);

  assign trig_o  = trig_q;
  assign state_o = state_q;

  function automatic logic [2:0] tgt(input logic [SW-1:0] code, input int k);
    tgt = 3'b000;
    case (code)
      4'd0: tgt = {1'b1, SF};
      4'd1: if (k == 1) tgt = {1'b1, S3};
      4'd2: if (k == 2) tgt = {1'b1, S2};
      4'd3: if (k == 1) tgt = {1'b1, S2};
      4'd4: if (k == 0) tgt = {1'b1, S2}; else if (k == 1) tgt = {1'b1, S3};
      4'd5: if (k == 0) tgt = {1'b1, SF}; else if (k == 1) tgt = {1'b1, S3};
      4'd6: if (k == 0) tgt = {1'b1, S2}; else if (k == 2) tgt = {1'b1, S3};
      4'd7: if (k != 2) tgt = {1'b1, S2};
      4'd9: if (k == 0) tgt = {1'b1, S3};
      default: tgt = 3'b000;
    endcase
  endfunction

  always_comb begin
    case (state_q)
      S1:      cur_code = sel_q[0];
      S2:      cur_code = sel_q[1];
      S3:      cur_code = sel_q[2];
      default: cur_code = 4'hF;
    endcase
  end

  always_comb begin
    eff       = armed_q ? (match_i & en_q) : '0;
    fin_hit   = 1'b0;
    any_hit   = 1'b0;
    fin_cause = '0;
    low_state = state_q;
    t         = 3'b000;
    for (int k = NM - 1; k >= 0; k--) begin
      t = tgt(cur_code, k);
      if (eff[k] && t[2]) begin
        if (t[1:0] == SF) begin
          fin_hit   = 1'b1;
          fin_cause = NM'(1 << k);
        end else begin
          any_hit   = 1'b1;
          low_state = t[1:0];
        end
      end
    end
    nxt_state = fin_hit ? SF : (any_hit ? low_state : state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
      en_q    <= '0;
      mflag_q <= '0;
      bank_q  <= '0;
      state_q <= S1;
      for (int s = 0; s < 3; s++) sel_q[s] <= '0;
    end else begin
      trig_q <= 1'b0;
      if (ctrl_wr) begin
        if (bus_wdata[DW-1] && !armed_q) begin
          state_q <= S1;
          mflag_q <= '0;
        end
        armed_q <= bus_wdata[DW-1];
        en_q    <= bus_wdata[4 +: NM];
        bank_q  <= bus_wdata[1:0];
      end else if (armed_q) begin
        state_q <= nxt_state;
        if (fin_hit) begin
          trig_q  <= 1'b1;
          armed_q <= 1'b0;
          mflag_q <= fin_cause;
        end
      end
      for (int s = 0; s < 3; s++)
        if (sel_wr && bank_q == 2'(s)) sel_q[s] <= bus_wdata[SW-1:0];
    end
  end

  always_comb begin
    if (!bus_addr) bus_rdata = DW'({armed_q, en_q, 2'b00, bank_q});
    else begin
      case (bank_q)
        2'd0:    bus_rdata = DW'(sel_q[0]);
        2'd1:    bus_rdata = DW'(sel_q[1]);
        2'd2:    bus_rdata = DW'(sel_q[2]);
        default: bus_rdata = DW'(mflag_q);
      endcase
    end
  end
endmodule

module dbg_trig_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [2:0] match_i,
  input logic       trig_o,
  input logic [1:0] state_o,
  input logic       armed_q,
  input logic [2:0] en_q,
  input logic [2:0] mflag_q,
  input logic [1:0] bank_q
);
  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o); // R8
  AST_TRIG_AT_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (state_o == 2'b11 && !armed_q && $countones(mflag_q) == 1)); // R8
  AST_ARM_TO_S1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr && bus_wdata[7] && !armed_q) |=> (armed_q && state_o == 2'b00 && mflag_q == 3'b000)); // R2
  AST_DISARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !(bus_wr && !bus_addr)) |=> ($stable(state_o) && !trig_o)); // R6
  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && (match_i & en_q) == 3'b000) |=> $stable(state_o)); // R6
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr && bank_q != 2'd3) |-> (bus_rdata[7:4] == 4'h0)); // R3
endmodule

bind dbg_trig_seq dbg_trig_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .match_i(match_i),
  .trig_o(trig_o), .state_o(state_o), .armed_q(armed_q), .en_q(en_q),
  .mflag_q(mflag_q), .bank_q(bank_q)
);

// File: tb/dbg_trig_seq_tb.sv
module dbg_trig_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] match_i = '0;
  logic       trig_o;
  logic [1:0] state_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural model
  int m_arm = 0, m_en = 0, m_bank = 0, m_state = 0, m_flag = 0, m_trig = 0;
  int m_sel[3] = '{0, 0, 0};

  dbg_trig_seq dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int tgt(int code, int k);
    // -1 none, 1 State2, 2 State3, 3 Final
    if (code == 0) return 3;
    if (code == 1 && k == 1) return 2;
    if (code == 2 && k == 2) return 1;
    if (code == 3 && k == 1) return 1;
    if (code == 4) return (k == 0) ? 1 : (k == 1) ? 2 : -1;
    if (code == 5) return (k == 0) ? 3 : (k == 1) ? 2 : -1;
    if (code == 6) return (k == 0) ? 1 : (k == 2) ? 2 : -1;
    if (code == 7) return (k < 2) ? 1 : -1;
    if (code == 9 && k == 0) return 2;
    return -1;
  endfunction

  function automatic int model_read(bit addr);
    if (!addr) return (m_arm << 7) | (m_en << 4) | m_bank;
    if (m_bank < 3) return m_sel[m_bank];
    return m_flag;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit wr, bit addr, int wdata, int match, string tag);
    int nst, ntrig, fin_k, low_t;
    @(negedge clk);
    bus_wr = wr; bus_addr = addr; bus_wdata = 8'(wdata); match_i = 3'(match);
    #1;
    check({tag, " read"}, int'(bus_rdata), model_read(addr));
    nst = m_state; ntrig = 0; fin_k = -1; low_t = -1;
    if (wr && !addr) begin
      if (wdata[7] && m_arm == 0) begin nst = 0; m_flag = 0; end
      m_arm = wdata[7]; m_en = (wdata >> 4) & 7; m_bank = wdata & 3;
    end else if (m_arm != 0) begin
      for (int k = 2; k >= 0; k--) begin
        if (((match & m_en) >> k) & 1) begin
          int tt = tgt(m_sel[m_state], k);
          if (tt == 3) fin_k = k;
          else if (tt > 0) low_t = tt;
        end
      end
      if (fin_k >= 0) begin
        nst = 3; ntrig = 1; m_arm = 0; m_flag = 1 << fin_k;
      end else if (low_t > 0) nst = low_t;
    end
    if (wr && addr && m_arm == 0 && m_bank < 3 && !(fin_k >= 0)) m_sel[m_bank] = wdata & 15;
    else if (wr && addr && fin_k >= 0 && m_bank < 3) ; // was armed at the edge: ignored
    m_state = nst; m_trig = ntrig;
    @(posedge clk); #1;
    check({tag, " state"}, int'(state_o), m_state);
    check({tag, " trig"}, int'(trig_o), m_trig);
  endtask

  function automatic int ctrl(int arm, int en, int bank);
    return (arm << 7) | (en << 4) | bank;
  endfunction

  task automatic setsel(int bank, int code, string tag);
    cyc(1, 0, ctrl(0, 7, bank), 0, tag);
    cyc(1, 1, code, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 state", int'(state_o), 0);
    check("R1 trig", int'(trig_o), 0);
    check("R1 ctrl", int'(bus_rdata), 0);
    cyc(0, 1, 0, 7, "R1");
    cyc(0, 0, 0, 7, "R1");

    // R3: selectors read back masked
    cyc(1, 0, ctrl(0, 7, 0), 0, "R2");
    cyc(1, 1, 8'hF4, 0, "R3");
    cyc(0, 1, 0, 0, "R3");
    setsel(1, 8'h35, "R3");
    cyc(0, 1, 0, 0, "R3");
    setsel(2, 8'h00, "R3");
    // R4: bank 11 write ignored
    cyc(1, 0, ctrl(0, 7, 3), 0, "R4");
    cyc(1, 1, 8'hFF, 0, "R4");
    cyc(0, 1, 0, 0, "R4");
    // arm, then write while armed ignored
    cyc(1, 0, ctrl(1, 7, 0), 0, "R2");
    cyc(1, 1, 8'h0A, 0, "R4");
    cyc(0, 1, 0, 0, "R4");
    cyc(0, 1, 0, 4, "R6");        // Match2 not named by 0100
    cyc(0, 1, 0, 3, "R7");        // Match0+Match1 -> State2
    cyc(0, 1, 0, 4, "R6");        // 0101 does not name Match2
    cyc(0, 1, 0, 3, "R7");        // Final wins over State3
    cyc(1, 0, ctrl(0, 7, 3), 0, "R8");
    cyc(0, 1, 0, 7, "R8");        // flags, Final held
    // disabled channels
    cyc(1, 0, ctrl(1, 0, 0), 0, "R2");
    cyc(0, 1, 0, 7, "R6");
    cyc(1, 0, ctrl(0, 0, 0), 0, "R2");
    cyc(0, 0, 0, 7, "R6");        // disarmed holds
    // reserved codes
    setsel(0, 8, "R5");
    cyc(1, 0, ctrl(1, 7, 0), 0, "R5");
    cyc(0, 1, 0, 7, "R5");
    setsel(0, 15, "R5");
    cyc(1, 0, ctrl(1, 7, 0), 0, "R5");
    cyc(0, 1, 0, 7, "R5");
    // every listed code against each single match, from State1
    for (int code = 0; code < 10; code++)
      for (int k = 0; k < 3; k++) begin
        setsel(0, code, "R5");
        cyc(1, 0, ctrl(1, 7, 0), 0, "R5");
        cyc(0, 0, 0, 1 << k, "R5");
        cyc(0, 0, 0, 0, "R5");
      end
    // same table from State2 and State3
    setsel(0, 4, "R5"); setsel(1, 9, "R5"); setsel(2, 5, "R5");
    cyc(1, 0, ctrl(1, 7, 0), 0, "R5");
    cyc(0, 0, 0, 2, "R5");        // to State3
    cyc(0, 0, 0, 6, "R7");        // 0101 in State3: Match1 -> State3
    cyc(0, 0, 0, 1, "R8");        // Match0 -> Final
    // random stream
    for (int i = 0; i < 3000; i++) begin
      bit wr = ($urandom % 6) == 0;
      cyc(wr, 1'($urandom), int'($urandom % 256), int'($urandom % 8), "R7");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule